// File: doc/BRIEF.md
# Cascaded Bit-Slice Arithmetic Logic Unit

This block is a word-wide arithmetic logic unit made from a chain of identical one-bit cells. A two-bit operation code picks one of four functions: bitwise AND, bitwise OR, the complement of the B word, or the sum of both words with an incoming carry. Three operand controls act before the function is applied. One lets the A word through or replaces it with zeros. One does the same for the B word. One inverts the A word after that gating.

These controls let the same cells produce derived results. Subtraction, negation, increment and constant words come from choosing the right control settings, with no extra hardware. The carry moves from each cell to the next more significant one. The final carry is an output.

The core is purely combinational. The top registers the result word and the carry so that the block can be driven and observed on a clock.

Top module: `bitslice_alu`

## Requirements
- R1: With opSel = 2'b00, enA = 1, enB = 1 and invA = 0, the result is opA & opB.
- R2: With opSel = 2'b01 and normal controls (enA = 1, enB = 1, invA = 0), the result is opA | opB.
- R3: With opSel = 2'b10 and normal controls, the result is ~opB. opA has no effect on the result.
- R4: With opSel = 2'b11 and normal controls, {carryOut, result} equals opA + opB + carryIn, computed at width+1 bits.
- R5: With enA = 0 and invA = 0, every operation treats the A operand as all zeros.
- R6: With enB = 0, every operation treats the B operand as all zeros. For example, opSel = 2'b10 then gives all ones.
- R7: invA = 1 complements the A operand after the enA gating. So enA = 0 with invA = 1 makes the A operand all ones.
- R8: For every opSel other than 2'b11, carryOut is 0.
- R9: With opSel = 2'b11, enA = 1, enB = 1, invA = 1 and carryIn = 1, result equals opB - opA modulo 2^WIDTH. In that case carryOut is 1 exactly when opB >= opA (unsigned).
- R10: result and carryOut update on the rising clkIn edge that follows a change of inputs, and not before that edge. While rstN is low, both outputs read 0.
- R11: A carry generated in the least significant cell reaches the most significant cell. For example, all-ones + 0 + carryIn = 1 gives result 0 and carryOut 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Clock; outputs are captured on its rising edge |
| rstN | input | 1 | Active-low synchronous reset of the output registers |
| opSel | input | 2 | Operation code: 00 AND, 01 OR, 10 NOT B, 11 sum |
| enA | input | 1 | 1 passes opA, 0 replaces it with zeros |
| enB | input | 1 | 1 passes opB, 0 replaces it with zeros |
| invA | input | 1 | 1 inverts the gated A operand |
| opA | input | WIDTH | A operand word |
| opB | input | WIDTH | B operand word |
| carryIn | input | 1 | Carry into the least significant cell |
| result | output | WIDTH | Registered result word |
| carryOut | output | 1 | Registered carry from the most significant cell |

## Verification
The hardest case to reach is a carry that travels through every cell. It happens only when all the propagate terms are set at once. Uniformly random words almost never do that.

The stimulus therefore adds directed vectors: all ones plus a carry-in, and a subtraction of equal words with inverted A. Random vectors are also biased so that about a quarter of the operands are all ones or zero. The rarely used control combinations are forced in the same way, such as gated-off A with inversion, which gives an all-ones operand.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_NOTB = 2'b10,
    OP_SUM  = 2'b11
  } aluOp_e;

  // strobes from the control decoder to every slice
  typedef struct packed {
    logic enAnd;
    logic enOr;
    logic enNotB;
    logic enSum;
    logic keepA;
    logic keepB;
    logic flipA;
  } sliceCtl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [1:0] opSel,
  input  logic       enA,
  input  logic       enB,
  input  logic       invA,
  output sliceCtl_t  ctl
);

  logic [3:0] opOneHot;

  // 2-to-4 decoder: exactly one operation enable is active
  always_comb begin
    opOneHot = '0;
    opOneHot[opSel] = 1'b1;
  end

  always_comb begin
    ctl.enAnd  = opOneHot[OP_AND];
    ctl.enOr   = opOneHot[OP_OR];
    ctl.enNotB = opOneHot[OP_NOTB];
    ctl.enSum  = opOneHot[OP_SUM];
    ctl.keepA  = enA;
    ctl.keepB  = enB;
    ctl.flipA  = invA;
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  sliceCtl_t ctl,
  input  logic      aBit,
  input  logic      bBit,
  input  logic      cIn,
  output logic      yBit,
  output logic      cOut
);

  logic aCond;
  logic bCond;
  logic halfSum;

  always_comb begin
    // gate first, then invert: a gated-off A with flipA reads as 1
    aCond   = (aBit & ctl.keepA) ^ ctl.flipA;
    bCond   = bBit & ctl.keepB;
    halfSum = aCond ^ bCond;
    yBit    = (ctl.enAnd  & aCond & bCond)
            | (ctl.enOr   & (aCond | bCond))
            | (ctl.enNotB & ~bCond)
            | (ctl.enSum  & (halfSum ^ cIn));
    cOut    = ctl.enSum & ((aCond & bCond) | (halfSum & cIn));
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  sliceCtl_t          ctl,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic               carryIn,
  output logic [WIDTH-1:0]   sumWord,
  output logic               carryLast
);

  localparam int CHAIN = WIDTH + 1;

  logic [CHAIN-1:0] carryChain;

  assign carryChain[0] = carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice u_slice (
      .ctl  (ctl),
      .aBit (opA[i]),
      .bBit (opB[i]),
      .cIn  (carryChain[i]),
      .yBit (sumWord[i]),
      .cOut (carryChain[i+1])
    );
  end

  assign carryLast = carryChain[CHAIN-1];

  // R1 R2 R3 R4: the strobes from the decoder select exactly one operation
  always_comb begin
    a_r1_one_op: assert ($onehot({ctl.enAnd, ctl.enOr, ctl.enNotB, ctl.enSum}))
      else $error("operation strobes not one-hot");
  end

  // R8: no carry leaves the chain unless the sum is selected
  always_comb begin
    a_r8_no_logic_carry: assert (ctl.enSum || !carryLast)
      else $error("carry out during a logic operation");
  end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic [1:0]       opSel,
  input  logic             enA,
  input  logic             enB,
  input  logic             invA,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  localparam int EXT = WIDTH + 1;

  sliceCtl_t        ctl;
  logic [WIDTH-1:0] coreWord;
  logic             coreCarry;
  logic             pastValid;

  alu_ctrl u_ctrl (
    .opSel (opSel),
    .enA   (enA),
    .enB   (enB),
    .invA  (invA),
    .ctl   (ctl)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .ctl       (ctl),
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .sumWord   (coreWord),
    .carryLast (coreCarry)
  );

  always_ff @(posedge clkIn) begin
    if (!rstN) begin
      result    <= '0;
      carryOut  <= 1'b0;
      pastValid <= 1'b0;
    end else begin
      result    <= coreWord;
      carryOut  <= coreCarry;
      pastValid <= 1'b1;
    end
  end

  // R4: normal-mode sum matches the arithmetic sum
  a_r4_sum: assert property (@(posedge clkIn) disable iff (!rstN)
    (pastValid && $past(opSel) == OP_SUM && $past(enA) && $past(enB) && !$past(invA))
    |-> ({carryOut, result} ==
         (EXT'($past(opA)) + EXT'($past(opB)) + EXT'($past(carryIn)))))
    else $error("sum mismatch");

  // R9: inverted A with carry-in gives B - A
  a_r9_subtract: assert property (@(posedge clkIn) disable iff (!rstN)
    (pastValid && $past(opSel) == OP_SUM && $past(enA) && $past(enB)
     && $past(invA) && $past(carryIn))
    |-> (result == WIDTH'($past(opB) - $past(opA))))
    else $error("subtract mismatch");

  // R5 R6: both operands gated off make AND zero
  a_r6_zero_operands: assert property (@(posedge clkIn) disable iff (!rstN)
    (pastValid && $past(opSel) == OP_AND && !$past(enA) && !$past(enB))
    |-> (result == '0))
    else $error("gated operands not zero");

  // R8: logic operations never produce a carry at the output
  a_r8_carry_quiet: assert property (@(posedge clkIn) disable iff (!rstN)
    (pastValid && $past(opSel) != OP_SUM) |-> !carryOut)
    else $error("carry after logic op");

  // R10: outputs hold while the reset that just ended was active
  a_r10_reset_clear: assert property (@(posedge clkIn)
    (rstN && !$past(rstN)) |-> (result == '0 && !carryOut))
    else $error("outputs not cleared by reset");

endmodule

// File: tb/bitslice_alu_test.sv
module bitslice_alu_test;

  localparam int W = 16;
  localparam logic [W-1:0] ONES = '1;

  logic         clkIn = 1'b0;
  logic         rstN;
  logic [1:0]   opSel;
  logic         enA, enB, invA, carryIn;
  logic [W-1:0] opA, opB;
  logic [W-1:0] result;
  logic         carryOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bitslice_alu #(.WIDTH(W)) uut (
    .clkIn(clkIn), .rstN(rstN), .opSel(opSel), .enA(enA), .enB(enB),
    .invA(invA), .opA(opA), .opB(opB), .carryIn(carryIn),
    .result(result), .carryOut(carryOut)
  );

  always #5 clkIn = ~clkIn;

  function automatic logic [W:0] model(logic [1:0] op, logic ea, logic eb,
                                       logic ia, logic [W-1:0] a,
                                       logic [W-1:0] b, logic ci);
    logic [W-1:0] ac, bc;
    ac = ea ? a : '0;
    if (ia) ac = ~ac;
    bc = eb ? b : '0;
    case (op)
      2'b00:   return {1'b0, ac & bc};
      2'b01:   return {1'b0, ac | bc};
      2'b10:   return {1'b0, ~bc};
      default: return {1'b0, ac} + {1'b0, bc} + {{W{1'b0}}, ci};
    endcase
  endfunction

  function automatic string resTag(logic [1:0] op, logic ea, logic eb,
                                   logic ia, logic ci);
    if (op == 2'b11 && ea && eb && ia && ci) return "R9";
    if (ia) return "R7";
    if (!ea) return "R5";
    if (!eb) return "R6";
    case (op)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic checkVal(string tag, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] op, logic ea, logic eb, logic ia,
                       logic [W-1:0] a, logic [W-1:0] b, logic ci,
                       string tagOverride);
    logic [W:0] exp;
    string rt, ct;
    opSel = op; enA = ea; enB = eb; invA = ia; opA = a; opB = b; carryIn = ci;
    exp = model(op, ea, eb, ia, a, b, ci);
    rt = (tagOverride != "") ? tagOverride : resTag(op, ea, eb, ia, ci);
    ct = (op != 2'b11) ? "R8" : ((ea && eb && ia && ci) ? "R9" : "R4");
    @(posedge clkIn);
    @(negedge clkIn);
    checkVal(rt, {1'b0, result}, {1'b0, exp[W-1:0]});
    checkVal(ct, {{W{1'b0}}, carryOut}, {{W{1'b0}}, exp[W]});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; opSel = 2'b11; enA = 1; enB = 1; invA = 0;
    opA = ONES; opB = ONES; carryIn = 1;
    repeat (3) @(posedge clkIn);
    @(negedge clkIn);
    // R10: reset state
    checkVal("R10", {carryOut, result}, '0);
    rstN = 1'b1;

    // directed corners
    apply(2'b00, 1, 1, 0, 16'hF0F0, 16'hFF00, 0, "");   // R1
    apply(2'b01, 1, 1, 0, 16'hF0F0, 16'h0F01, 1, "");   // R2
    apply(2'b10, 1, 1, 0, 16'h1234, 16'h00FF, 1, "R3"); // R3
    apply(2'b10, 1, 1, 0, 16'hFFFF, 16'h00FF, 0, "R3"); // R3 opA ignored
    apply(2'b11, 1, 1, 0, ONES, 16'h0000, 1, "R11");    // R11 full ripple
    apply(2'b11, 1, 1, 0, 16'h8000, 16'h8000, 0, "R4");
    apply(2'b01, 0, 1, 0, 16'hAAAA, 16'h0101, 0, "R5");
    apply(2'b10, 1, 0, 0, 16'h5555, 16'h3333, 0, "R6");
    apply(2'b00, 0, 1, 1, 16'h0000, 16'h5A5A, 0, "R7");
    apply(2'b11, 1, 1, 1, 16'h0007, 16'h0007, 1, "R9");  // equal -> 0, carry 1
    apply(2'b11, 1, 1, 1, 16'h0009, 16'h0002, 1, "R9");  // borrow -> carry 0
    apply(2'b11, 0, 1, 1, 16'h1111, 16'h0000, 1, "R7");  // -1 + 0 + 1

    // R10: no change before the capturing edge
    opSel = 2'b10; opB = 16'h0000; enB = 1;
    #2;
    checkVal("R10", {carryOut, result}, {1'b1, 16'h0000});
    @(posedge clkIn);
    @(negedge clkIn);
    checkVal("R10", {carryOut, result}, {1'b0, ONES});

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] a, b;
      logic [3:0] pick;
      a = W'($urandom); b = W'($urandom);
      pick = 4'($urandom);
      if (pick[1:0] == 0) a = pick[2] ? ONES : '0;
      if (pick[3:2] == 0) b = pick[0] ? ONES : '0;
      apply(2'($urandom), ($urandom % 5) != 0, ($urandom % 5) != 0,
            ($urandom % 3) == 0, a, b, 1'($urandom), "");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule